// File: doc/BRIEF.md
# Prescaled Compare-Match Timer

A memory-mapped timer built around a free-running up-counter (32 bits by default). The counter advances on strobes from one of several selectable tick sources, after division by a programmable prescaler. Three compare channels each hold a value. When the counter steps onto that value, the channel's status flag sets. The flags are cleared by writing ones. Each flag is gated by its own interrupt enable into one level interrupt.

Low-power mode indications arrive as plain inputs. For each mode a run-enable bit chooses whether the counter keeps going or freezes while that mode is active. A self-clearing software reset returns the block to its defaults. It leaves the clock-source selection, the fast-source enable and the run enables untouched, so the timing setup survives.

Registers are 32 bits wide and word addressed: control 0x00, prescaler 0x04, status 0x08, interrupt enable 0x0C, compare channels 0x10/0x14/0x18, counter 0x24. Control bits: bit 0 run, bits 3:1 source code, bit 4 fast-source enable, bits 8:5 low-power run enables (5 stop, 6 doze, 7 wait, 8 debug), bit 15 software reset.

Top module: `cmp_timer`

## Requirements
- R1: After rst_ni the control, prescaler, status and enable registers read 0, every compare register reads all-ones, the counter reads 0 and irq_o is low.
- R2: The counter advances only while control bit 0 is set. It follows the strobe picked by source code 1 periph, 2 periph_hi, 3 ext, 4 slow, or 5 fast (fast also needs bit 4). Codes 0, 6 and 7 select nothing.
- R3: With prescaler value n (bits 11:0 at 0x04), the counter advances once per n+1 selected strobes; n = 0 means no division.
- R4: The counter only holds or steps by one, and it wraps from all-ones to zero past every compare value.
- R5: When a low-power input is high and its run enable in control bits 8:5 is clear, the counter holds; with the enable set it keeps counting.
- R6: Status bit i-1 sets on the clock edge where the counter takes a value equal to compare register i.
- R7: Writing status clears exactly the bits written as 1; a match in the same cycle as the clear of that bit leaves it set.
- R8: irq_o is the OR over channels of status AND enable; clearing an enable masks irq_o without changing the flag.
- R9: Writing control with bit 15 set starts a software reset. Bit 15 reads 1 for exactly 4 cycles and then 0. The run bit, prescaler, status, enables, compares and counter return to R1 values, while bits 8:1 keep their values. Bus writes are dropped during the reset.
- R10: Reads return data one cycle after the request; writes to the counter address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| tick_periph_i | input | 1 | Peripheral clock strobe |
| tick_periph_hi_i | input | 1 | High-rate peripheral clock strobe |
| tick_ext_i | input | 1 | External clock strobe |
| tick_slow_i | input | 1 | 32 kHz strobe |
| tick_fast_i | input | 1 | 24 MHz strobe |
| lp_stop_i | input | 1 | Stop mode active |
| lp_doze_i | input | 1 | Doze mode active |
| lp_wait_i | input | 1 | Wait mode active |
| lp_debug_i | input | 1 | Debug mode active |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume rst_ni is asserted before the first edge and that bus inputs are stable across the sampling edge. They also assume a status write is the only thing that can clear a flag outside a software reset. The bench changes every input on the falling edge, holds each strobe high for whole cycles, and issues one bus access per cycle. It waits out the software reset before it writes again, so no dropped write is mistaken for a fault. The sweeps use an 8-bit counter so that the counter wraps within a few hundred strobes.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned N_SRC  = 5;
  localparam int unsigned N_LP   = 4;

  // word index = addr[5:2]
  localparam logic [3:0] WD_CTRL = 4'd0;
  localparam logic [3:0] WD_PSC  = 4'd1;
  localparam logic [3:0] WD_STAT = 4'd2;
  localparam logic [3:0] WD_IE   = 4'd3;
  localparam logic [3:0] WD_CMP0 = 4'd4;
  localparam logic [3:0] WD_CNT  = 4'd9;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_SRC  = 1;
  localparam int unsigned CB_FAST = 4;
  localparam int unsigned CB_LP   = 5;
  localparam int unsigned CB_SWR  = 15;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_PER   = 3'd1,
    SRC_PERHI = 3'd2,
    SRC_EXT   = 3'd3,
    SRC_SLOW  = 3'd4,
    SRC_FAST  = 3'd5
  } src_e;
endpackage

// File: rtl/cmp_timer_step.sv
module cmp_timer_step
  import cmp_timer_pkg::*;
#(
  parameter int unsigned PSC_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] tick_i,
  input  logic [2:0]       src_i,
  input  logic             fast_en_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [PSC_W-1:0] lim_i,
  output logic             inc_o
);
  logic             sel;
  logic             step;
  logic [PSC_W-1:0] div_q;
  logic             at_lim;

  always_comb begin
    unique case (src_i)
      SRC_PER:   sel = tick_i[0];
      SRC_PERHI: sel = tick_i[1];
      SRC_EXT:   sel = tick_i[2];
      SRC_SLOW:  sel = tick_i[3];
      SRC_FAST:  sel = tick_i[4] & fast_en_i;
      default:   sel = 1'b0;
    endcase
  end

  assign step   = sel & run_i;
  assign at_lim = (div_q >= lim_i);  // tolerates a limit lowered mid-count

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (step)   div_q <= at_lim ? '0 : div_q + 1'b1;
  end

  assign inc_o = step & at_lim;
endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ack_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             flag_o
);
  logic hit;

  assign hit = inc_i & (cnt_nxt_i == cmp_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cmp_o <= '1;
    else if (clr_i) cmp_o <= '1;
    else if (wr_i)  cmp_o <= wdata_i;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else            flag_o <= (flag_o & ~ack_i) | hit;
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned PSC_W      = 12,
  parameter int unsigned N_CMP      = 3,
  parameter int unsigned SWR_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_periph_i,
  input  logic              tick_periph_hi_i,
  input  logic              tick_ext_i,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  input  logic              lp_stop_i,
  input  logic              lp_doze_i,
  input  logic              lp_wait_i,
  input  logic              lp_debug_i,
  output logic              irq_o
);
  localparam int unsigned SWR_W = $clog2(SWR_CYCLES + 1);

  logic [3:0]       word;
  logic             wr, rd;
  logic             wr_ctrl, wr_psc, wr_stat, wr_ie;
  logic             run_q, fast_en_q;
  logic [2:0]       src_q;
  logic [N_LP-1:0]  lp_run_q;
  logic [N_LP-1:0]  lp_act;
  logic [SWR_W-1:0] swr_q;
  logic             busy;
  logic [PSC_W-1:0] psc_q;
  logic [N_CMP-1:0] ie_q;
  logic [N_CMP-1:0] stat_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] cmp_q [N_CMP];
  logic             lp_ok, run, inc;
  logic [DATA_W-1:0] rd_d;
  logic             unused_bits;

  assign unused_bits = ^{addr_i[1:0], wdata_i};

  assign busy    = (swr_q != '0);
  assign word    = addr_i[5:2];
  assign wr      = req_i & we_i & ~busy;
  assign rd      = req_i & ~we_i;
  assign wr_ctrl = wr & (word == WD_CTRL);
  assign wr_psc  = wr & (word == WD_PSC);
  assign wr_stat = wr & (word == WD_STAT);
  assign wr_ie   = wr & (word == WD_IE);

  // control; swr write leaves preserved fields alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      src_q     <= SRC_NONE;
      fast_en_q <= 1'b0;
      lp_run_q  <= '0;
      swr_q     <= '0;
    end else if (wr_ctrl) begin
      if (wdata_i[CB_SWR]) begin
        swr_q <= SWR_W'(SWR_CYCLES);
        run_q <= 1'b0;
      end else begin
        run_q     <= wdata_i[CB_RUN];
        src_q     <= wdata_i[CB_SRC+:3];
        fast_en_q <= wdata_i[CB_FAST];
        lp_run_q  <= wdata_i[CB_LP+:N_LP];
      end
    end else if (busy) begin
      swr_q <= swr_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      ie_q  <= '0;
    end else if (busy) begin
      psc_q <= '0;
      ie_q  <= '0;
    end else begin
      if (wr_psc) psc_q <= wdata_i[PSC_W-1:0];
      if (wr_ie)  ie_q  <= wdata_i[N_CMP-1:0];
    end
  end

  assign lp_act = {lp_debug_i, lp_wait_i, lp_doze_i, lp_stop_i};
  assign lp_ok  = ~|(lp_act & ~lp_run_q);
  assign run    = run_q & lp_ok & ~busy;

  cmp_timer_step #(.PSC_W(PSC_W)) i_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    ({tick_fast_i, tick_slow_i, tick_ext_i, tick_periph_hi_i, tick_periph_i}),
    .src_i     (src_q),
    .fast_en_i (fast_en_q),
    .run_i     (run),
    .clr_i     (busy),
    .lim_i     (psc_q),
    .inc_o     (inc)
  );

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (busy) cnt_q <= '0;
    else if (inc)  cnt_q <= cnt_nxt;
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_chan
    cmp_timer_chan #(.CNT_W(CNT_W)) i_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (busy),
      .wr_i      (wr & (word == WD_CMP0 + 4'(i))),
      .wdata_i   (wdata_i[CNT_W-1:0]),
      .ack_i     (wr_stat & wdata_i[i]),
      .inc_i     (inc),
      .cnt_nxt_i (cnt_nxt),
      .cmp_o     (cmp_q[i]),
      .flag_o    (stat_q[i])
    );
  end

  assign irq_o = |(stat_q & ie_q);

  always_comb begin
    rd_d = '0;
    unique case (word)
      WD_CTRL: begin
        rd_d[CB_RUN]         = run_q;
        rd_d[CB_SRC+:3]      = src_q;
        rd_d[CB_FAST]        = fast_en_q;
        rd_d[CB_LP+:N_LP]    = lp_run_q;
        rd_d[CB_SWR]         = busy;
      end
      WD_PSC:  rd_d[PSC_W-1:0] = psc_q;
      WD_STAT: rd_d[N_CMP-1:0] = stat_q;
      WD_IE:   rd_d[N_CMP-1:0] = ie_q;
      WD_CNT:  rd_d[CNT_W-1:0] = cnt_q;
      default: rd_d = '0;
    endcase
    for (int i = 0; i < N_CMP; i++)
      if (word == WD_CMP0 + 4'(i)) rd_d[CNT_W-1:0] = cmp_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_d;
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned N_CMP = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              lp_stop_i,
  input logic [N_LP-1:0]   lp_run_i,
  input logic              busy_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [N_CMP-1:0]  stat_i,
  input logic [N_CMP-1:0]  ie_i,
  input logic              irq_o
);
  logic ack0;
  assign ack0 = req_i & we_i & (addr_i[5:2] == WD_STAT) & wdata_i[0];

  assert_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_stop_i && !lp_run_i[0] && !busy_i) |=> (cnt_i == $past(cnt_i)));

  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> ((cnt_i == $past(cnt_i)) || (cnt_i == CNT_W'($past(cnt_i) + 1'b1))));

  assert_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_i == '0) |-> !irq_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i[0] && !busy_i && !ack0) |=> stat_i[0]);

  // reset length fixed at 4 cycles
  assert_swr_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> ($past(busy_i, 4) && !$past(busy_i, 5)));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .N_CMP(N_CMP)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .lp_stop_i (lp_stop_i),
  .lp_run_i  (lp_run_q),
  .busy_i    (busy),
  .cnt_i     (cnt_q),
  .stat_i    (stat_q),
  .ie_i      (ie_q),
  .irq_o     (irq_o)
);

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  tk = '0;
  logic [3:0]  lp = '0;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_timer #(.CNT_W(CW)) i_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata),
    .tick_periph_i(tk[0]), .tick_periph_hi_i(tk[1]), .tick_ext_i(tk[2]),
    .tick_slow_i(tk[3]), .tick_fast_i(tk[4]),
    .lp_stop_i(lp[0]), .lp_doze_i(lp[1]), .lp_wait_i(lp[2]), .lp_debug_i(lp[3]),
    .irq_o(irq)
  );

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata; req = 1'b0;
  endtask

  task automatic pulse(input int j, input int n);
    repeat (n) begin
      tk = 5'b1 << j;
      @(negedge clk);
    end
    tk = '0;
  endtask

  task automatic soft_rst();
    wr(6'h00, 32'h8000);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(6'h00, v); check("R1 ctrl", v, 0);
    rd(6'h04, v); check("R1 prescaler", v, 0);
    rd(6'h08, v); check("R1 status", v, 0);
    rd(6'h0C, v); check("R1 enable", v, 0);
    for (int i = 0; i < 3; i++) begin
      rd(6'h10 + 6'(4*i), v); check("R1 compare", v, 32'hFF);
    end
    rd(6'h24, v); check("R1 counter", v, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // R2 run bit clear: no counting
    wr(6'h00, 32'h2);
    pulse(0, 3);
    rd(6'h24, v); check("R2 run off", v, 0);

    // R2 source sweep
    for (int code = 0; code < 8; code++) begin
      for (int f = 0; f < 2; f++) begin
        int exp;
        soft_rst();
        wr(6'h00, 32'(1 | (code << 1) | (f << 4)));
        exp = 0;
        for (int j = 0; j < 5; j++) begin
          pulse(j, 2);
          if (code == j + 1 && (j != 4 || f == 1)) exp += 2;
        end
        rd(6'h24, v); check($sformatf("R2 src %0d fast %0d", code, f), v, 32'(exp));
      end
    end

    // R3 prescaler sweep
    for (int n = 0; n < 8; n++) begin
      soft_rst();
      wr(6'h04, 32'(n));
      wr(6'h00, 32'h3);
      pulse(0, 24);
      rd(6'h24, v); check($sformatf("R3 div %0d", n + 1), v, 32'(24 / (n + 1)));
    end

    // R5 low-power sweep
    for (int k = 0; k < 4; k++) begin
      for (int en = 0; en < 2; en++) begin
        soft_rst();
        wr(6'h00, 32'(3 | (en << (5 + k))));
        lp = 4'b1 << k;
        pulse(0, 3);
        lp = '0;
        rd(6'h24, v); check($sformatf("R5 mode %0d en %0d", k, en), v, en ? 3 : 0);
      end
    end

    // R6 compare / R4 wrap
    soft_rst();
    wr(6'h10, 32'h05); wr(6'h14, 32'hFF); wr(6'h18, 32'h00);
    wr(6'h00, 32'h3);
    pulse(0, 4);
    rd(6'h08, v); check("R6 no match yet", v, 0);
    pulse(0, 1);
    rd(6'h08, v); check("R6 match ch1", v, 1);
    rd(6'h24, v); check("R6 counter at cmp", v, 5);
    pulse(0, 250);
    rd(6'h24, v); check("R4 all ones", v, 32'hFF);
    rd(6'h08, v); check("R6 match ch2", v, 3);
    pulse(0, 1);
    rd(6'h24, v); check("R4 wrap", v, 0);
    rd(6'h08, v); check("R6 match ch3 on wrap", v, 7);

    // R10 counter write ignored
    wr(6'h24, 32'h40);
    rd(6'h24, v); check("R10 counter write", v, 0);

    // R8 interrupt gating
    check("R8 irq masked", {31'b0, irq}, 0);
    wr(6'h0C, 32'h2);
    check("R8 irq on", {31'b0, irq}, 1);
    wr(6'h0C, 32'h0);
    check("R8 irq off", {31'b0, irq}, 0);
    rd(6'h08, v); check("R8 flags kept", v, 7);

    // R7 w1c
    wr(6'h08, 32'h5);
    rd(6'h08, v); check("R7 partial clear", v, 2);
    wr(6'h0C, 32'h2);
    check("R8 irq ch2", {31'b0, irq}, 1);
    wr(6'h08, 32'h2);
    rd(6'h08, v); check("R7 clear all", v, 0);
    check("R8 irq after clear", {31'b0, irq}, 0);

    // R7 set beats clear
    wr(6'h10, 32'h01);
    pulse(0, 1);
    rd(6'h08, v); check("R7 preset", v, 1);
    wr(6'h10, 32'h02);
    req = 1'b1; we = 1'b1; addr = 6'h08; wdata = 32'h1; tk = 5'b1;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tk = '0;
    rd(6'h08, v); check("R7 collision", v, 1);
    rd(6'h24, v); check("R7 counter", v, 2);
    wr(6'h08, 32'h1);
    rd(6'h08, v); check("R7 cleared", v, 0);

    // R9 software reset
    wr(6'h04, 32'h3); wr(6'h0C, 32'h7); wr(6'h10, 32'h11);
    wr(6'h00, 32'h1FB);
    pulse(4, 8);
    wr(6'h00, 32'h8000);
    for (int i = 0; i < 5; i++) begin
      rd(6'h00, v);
      check($sformatf("R9 busy cycle %0d", i), v, (i < 4) ? 32'h81FA : 32'h01FA);
    end
    rd(6'h04, v); check("R9 prescaler", v, 0);
    rd(6'h0C, v); check("R9 enable", v, 0);
    rd(6'h08, v); check("R9 status", v, 0);
    rd(6'h10, v); check("R9 compare", v, 32'hFF);
    rd(6'h24, v); check("R9 counter", v, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule